// File: doc/BRIEF.md
# Multi-queue transmit trigger scheduler

This block decides which of up to ten transmit queues is offered next to the channel-access stage. Every queue keeps a count of frames waiting and has a static configuration: a type code, an enable bit, and three optional gates. The first gate is a constant-rate timer with an overflow threshold. The second is a ready window that opens when the queue is triggered. The third is a limit on how long one queue may hold the channel across back-to-back frames.

On each idle cycle the scheduler picks one eligible queue. A beacon queue always comes first; among the other queues the highest index wins. The pick is held on `sel_idx` with `sel_valid` high until the downstream stage pulses `done`. The `done` pulse retires one frame from the selected queue, and the following cycle is the next decision cycle.

The type codes are 0 (inactive), 1 (data), 2 (beacon), 3 (after-beacon traffic) and 4 (power-save delivery). Codes 4 to 7 are scheduled like data. All per-queue configuration vectors pack queue i at bits [W*i +: W].

Top module: `txq_sched`

## Requirements
- R1: After reset `sel_valid` is 0, and every pending count, `q_active` bit and `cbr_ovf` bit is 0.
- R2: A queue's pending count rises by one on its `enq` strobe and falls by one on a `done` pulse while it is the selected queue. The count stays unchanged when both happen together, saturates at 2^CW-1 and never goes below zero.
- R3: A queue with type code 0 ignores `enq`, reads a pending count of 0, is never selected and reports `q_active` 0.
- R4: `q_active[i]` is 1 exactly when the type code is nonzero and either the pending count is nonzero or `q_en[i]` is set. This includes an enabled queue with nothing pending.
- R5: A queue is eligible only when its type is nonzero, its enable bit is set, its pending count is nonzero and every configured gate is open. Among eligible queues that are not beacons, the highest index is selected, one cycle after the decision cycle.
- R6: A beacon queue (type 2) becomes eligible only after a `bcn_tick` pulse, and each pulse allows one grant. An eligible beacon queue is selected ahead of every other eligible queue.
- R7: Once a queue is selected, `sel_idx` and `sel_valid` hold until `done`. A higher-priority queue cannot preempt it, and a `done` pulse while nothing is selected has no effect.
- R8: With a nonzero `cbr_per` value P, the queue's timer triggers once every P cycles. Each trigger allows exactly one grant, and unused triggers accumulate.
- R9: When a constant-rate trigger occurs and is not used in the same cycle, `cbr_ovf[i]` pulses for one cycle if `cbr_thr` is nonzero and the number of unused triggers, this one included, exceeds it. It never pulses when the threshold is zero.
- R10: With a nonzero `rdy_time` value R, a trigger opens a window R cycles long, and the queue may only be selected inside it. The trigger is the constant-rate timer if one is configured, otherwise `bcn_tick` for a beacon queue, otherwise the queue's own `enq`. The window is not applied to type 3.
- R11: With a nonzero `burst_time` value B, a queue that has held the channel for B or more busy cycles across back-to-back grants is skipped for the next decision cycle. Another queue may take that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_type | input | 3*NQ | Per-queue type code |
| q_en | input | NQ | Per-queue enable |
| cbr_per | input | TW*NQ | Constant-rate period in cycles, 0 = off |
| cbr_thr | input | TW*NQ | Unused-trigger overflow threshold, 0 = off |
| rdy_time | input | TW*NQ | Ready window length in cycles, 0 = off |
| burst_time | input | TW*NQ | Back-to-back channel hold limit in cycles, 0 = off |
| enq | input | NQ | Per-queue frame enqueue strobe |
| bcn_tick | input | 1 | Beacon time strobe |
| done | input | 1 | Downstream frame completion pulse |
| sel_valid | output | 1 | A queue is currently selected |
| sel_idx | output | IW | Index of the selected queue |
| q_pend | output | CW*NQ | Per-queue pending count |
| q_active | output | NQ | Per-queue active status |
| cbr_ovf | output | NQ | Per-queue constant-rate overflow pulse |

## Verification
The bench targets the corner cases where a plausible mistake changes which queue is selected.
- A beacon that is pending but was never ticked must lose to a data queue, and must then overtake that queue once ticked. A design that ignored the beacon arming would pick queue 0 at the start, and one without beacon priority would return to queue 9.
- A selection must survive a higher queue arriving mid-frame, and a `done` while idle must not decrement anything. Getting this wrong shows up as a switched `sel_idx` or a lost count.
- The ready window is left to expire before the queue is enabled, so a design that skipped the window, or applied it to the after-beacon type, selects in the wrong test.
- Burst limiting and the constant-rate timer are measured as grant sequences and grant counts over a fixed number of cycles. A missing gate or an off-by-one period shows up as a wrong index or a count outside its band.

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int NQ = 10,
  parameter int CW = 4,
  parameter int TW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3*NQ-1:0]    q_type,
  input  logic [NQ-1:0]      q_en,
  input  logic [TW*NQ-1:0]   cbr_per,
  input  logic [TW*NQ-1:0]   cbr_thr,
  input  logic [TW*NQ-1:0]   rdy_time,
  input  logic [TW*NQ-1:0]   burst_time,
  input  logic [NQ-1:0]      enq,
  input  logic               bcn_tick,
  input  logic               done,
  output logic               sel_valid,
  output logic [((NQ > 1) ? $clog2(NQ) : 1)-1:0] sel_idx,
  output logic [CW*NQ-1:0]   q_pend,
  output logic [NQ-1:0]      q_active,
  output logic [NQ-1:0]      cbr_ovf
);
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [2:0] T_OFF = 3'd0;
  localparam logic [2:0] T_BCN = 3'd2;
  localparam logic [2:0] T_CAB = 3'd3;
  localparam logic [CW-1:0] PMAX = '1;
  localparam logic [TW-1:0] TMAX = '1;

  logic [2:0]    qt   [NQ];
  logic [TW-1:0] per  [NQ];
  logic [TW-1:0] thr  [NQ];
  logic [TW-1:0] rdy  [NQ];
  logic [TW-1:0] bst  [NQ];
  logic [CW-1:0] pend [NQ];
  logic [TW-1:0] ccnt [NQ];
  logic [TW-1:0] cred [NQ];
  logic [TW-1:0] win  [NQ];
  logic [NQ-1:0] arm, tick, trig, elig, isb, take;
  logic          busy, just_done, any, gnt, fin;
  logic [IW-1:0] cur, run_q, pick;
  logic [TW-1:0] run_cyc;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign qt[g]  = q_type[3*g +: 3];
    assign per[g] = cbr_per[TW*g +: TW];
    assign thr[g] = cbr_thr[TW*g +: TW];
    assign rdy[g] = rdy_time[TW*g +: TW];
    assign bst[g] = burst_time[TW*g +: TW];
    assign isb[g]  = qt[g] == T_BCN;
    assign tick[g] = per[g] != '0 && ccnt[g] == per[g] - 1'b1;
    assign trig[g] = (per[g] != '0) ? tick[g] : (isb[g] ? bcn_tick : enq[g]);
    assign elig[g] = qt[g] != T_OFF && q_en[g] && pend[g] != '0
                   && (per[g] == '0 || cred[g] != '0)
                   && (!isb[g] || arm[g])
                   && (rdy[g] == '0 || qt[g] == T_CAB || win[g] != '0)
                   && !(just_done && run_q == IW'(g) && bst[g] != '0 && run_cyc >= bst[g]);
    assign q_pend[CW*g +: CW] = pend[g];
    assign q_active[g] = qt[g] != T_OFF && (pend[g] != '0 || q_en[g]);

    // R9
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cbr_ovf[g] |-> $past(per[g]) != '0 && $past(thr[g]) != '0);
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NQ; i++) if (elig[i]) pick = IW'(i);
    for (int i = 0; i < NQ; i++) if (elig[i] && isb[i]) pick = IW'(i);
  end

  assign any  = |elig;
  assign gnt  = !busy && any;
  assign fin  = busy && done;
  assign take = gnt ? (NQ'(1) << pick) : '0;
  assign sel_valid = busy;
  assign sel_idx   = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur <= '0; run_q <= '0; run_cyc <= '0; just_done <= 1'b0;
      arm <= '0; cbr_ovf <= '0;
      for (int i = 0; i < NQ; i++) begin
        pend[i] <= '0; ccnt[i] <= '0; cred[i] <= '0; win[i] <= '0;
      end
    end else begin
      just_done <= fin;
      if (gnt) begin
        busy  <= 1'b1;
        cur   <= pick;
        run_q <= pick;
        if (!(just_done && pick == run_q)) run_cyc <= '0;
      end else if (busy) begin
        if (run_cyc != TMAX) run_cyc <= run_cyc + 1'b1;
        if (done) busy <= 1'b0;
      end
      for (int i = 0; i < NQ; i++) begin
        if (qt[i] == T_OFF) pend[i] <= '0;
        else if (enq[i] && !(fin && cur == IW'(i))) begin
          if (pend[i] != PMAX) pend[i] <= pend[i] + 1'b1;
        end else if (!enq[i] && fin && cur == IW'(i) && pend[i] != '0)
          pend[i] <= pend[i] - 1'b1;

        if (per[i] == '0 || tick[i]) ccnt[i] <= '0;
        else ccnt[i] <= ccnt[i] + 1'b1;

        if (per[i] == '0) cred[i] <= '0;
        else if (tick[i] && !take[i]) begin
          if (cred[i] != TMAX) cred[i] <= cred[i] + 1'b1;
        end else if (!tick[i] && take[i] && cred[i] != '0)
          cred[i] <= cred[i] - 1'b1;

        cbr_ovf[i] <= tick[i] && thr[i] != '0 && !take[i] && cred[i] >= thr[i];

        if (trig[i]) win[i] <= rdy[i];
        else if (win[i] != '0) win[i] <= win[i] - 1'b1;

        if (bcn_tick && isb[i]) arm[i] <= 1'b1;
        else if (take[i]) arm[i] <= 1'b0;
      end
    end
  end

  // R7
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(cur));
  // R6
  bcn_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt && |(elig & isb) |=> qt[cur] == T_BCN);
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pend[cur] != '0);
  // R3
  off_never_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> qt[cur] != T_OFF);
endmodule

// File: tb/txq_sched_tb.sv
`timescale 1ns/1ps
module txq_sched_tb;
  localparam int NQ = 10, CW = 4, TW = 8, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3*NQ-1:0] q_type;
  logic [NQ-1:0] q_en, enq, q_active, cbr_ovf;
  logic [TW*NQ-1:0] cbr_per, cbr_thr, rdy_time, burst_time;
  logic bcn_tick, done, sel_valid;
  logic [IW-1:0] sel_idx;
  logic [CW*NQ-1:0] q_pend;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txq_sched #(.NQ(NQ), .CW(CW), .TW(TW)) u_dut (
    .clk, .rst_n, .q_type, .q_en, .cbr_per, .cbr_thr, .rdy_time, .burst_time,
    .enq, .bcn_tick, .done, .sel_valid, .sel_idx, .q_pend, .q_active, .cbr_ovf);

  localparam logic [NQ-1:0] VMASK [6] = '{10'b0000000001, 10'b1000000001, 10'b0000110000,
                                          10'b0101000000, 10'b0000000110, 10'b0111111111};
  localparam int VEXP [6] = '{0, 9, 5, 8, 2, 8};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cfg_clear();
    q_type = '0; q_en = '0; cbr_per = '0; cbr_thr = '0; rdy_time = '0; burst_time = '0;
  endtask

  task automatic set_q(input int i, input logic [2:0] t, input logic e);
    q_type[3*i +: 3] = t; q_en[i] = e;
  endtask

  task automatic all_data();
    cfg_clear();
    for (int i = 0; i < NQ; i++) set_q(i, 3'd1, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enq = '0; done = 1'b0; bcn_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_enq(input logic [NQ-1:0] m);
    enq = m; @(negedge clk); enq = '0;
  endtask

  function automatic int pend_of(input int i);
    return int'(q_pend[CW*i +: CW]);
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    int g[3];
    int k;
    cfg_clear(); enq = '0; done = 1'b0; bcn_tick = 1'b0;

    // R1 reset state
    do_reset();
    chk("R1 sel_valid", int'(sel_valid), 0);
    chk("R1 pending", int'(q_pend != '0), 0);
    chk("R1 active", int'(q_active), 0);
    chk("R1 ovf", int'(cbr_ovf), 0);

    // R5 priority table
    for (int v = 0; v < 6; v++) begin
      all_data(); do_reset();
      pulse_enq(VMASK[v]);
      @(negedge clk);
      chk("R5 valid", int'(sel_valid), 1);
      chk("R5 index", int'(sel_idx), VEXP[v]);
    end

    // R4 enabled but empty is active; inactive with enable is not
    cfg_clear(); set_q(3, 3'd1, 1'b1); set_q(5, 3'd0, 1'b1); do_reset();
    chk("R4 active", int'(q_active), 32'h008);

    // R3 inactive queue ignores enq and is never picked
    all_data(); set_q(2, 3'd0, 1'b1); do_reset();
    repeat (3) pulse_enq(10'b0000000100);
    chk("R3 pending", pend_of(2), 0);
    chk("R3 not selected", int'(sel_valid), 0);
    chk("R3 active", int'(q_active[2]), 0);
    pulse_enq(10'b0000000110);
    @(negedge clk);
    chk("R3 lower queue wins", int'(sel_idx), 1);

    // R2 saturation, decrement, idle done ignored
    cfg_clear(); set_q(7, 3'd1, 1'b0); do_reset();
    enq = 10'b0010000000; repeat (20) @(negedge clk); enq = '0;
    chk("R2 saturate", pend_of(7), 15);
    q_en[7] = 1'b1; @(negedge clk);
    chk("R2 granted", int'(sel_idx), 7);
    done = 1'b1; @(negedge clk); done = 1'b0; q_en[7] = 1'b0;
    @(negedge clk);
    chk("R2 decrement", pend_of(7), 14);
    done = 1'b1; repeat (2) @(negedge clk); done = 1'b0;
    chk("R7 idle done ignored", pend_of(7), 14);
    chk("R7 idle stays idle", int'(sel_valid), 0);

    // R7 hold until done
    all_data(); do_reset();
    pulse_enq(10'b0000001000); @(negedge clk);
    chk("R7 first grant", int'(sel_idx), 3);
    pulse_enq(10'b1000000000); repeat (2) @(negedge clk);
    chk("R7 held index", int'(sel_idx), 3);
    chk("R7 held valid", int'(sel_valid), 1);
    done = 1'b1; @(negedge clk); done = 1'b0; @(negedge clk);
    chk("R7 next grant", int'(sel_idx), 9);

    // R6 beacon needs tick, then beats data
    cfg_clear(); set_q(0, 3'd2, 1'b1); set_q(9, 3'd1, 1'b1); do_reset();
    enq = 10'b1000000001; @(negedge clk); @(negedge clk); enq = '0;
    chk("R6 unarmed beacon loses", int'(sel_idx), 9);
    bcn_tick = 1'b1; @(negedge clk); bcn_tick = 1'b0;
    chk("R6 no preempt", int'(sel_idx), 9);
    done = 1'b1; @(negedge clk); done = 1'b0; @(negedge clk);
    chk("R6 beacon first", int'(sel_idx), 0);
    chk("R6 data still pending", pend_of(9), 1);

    // R8 constant-rate gating
    cfg_clear(); set_q(1, 3'd1, 1'b1); cbr_per[TW*1 +: TW] = 8'd4; do_reset();
    enq = 10'b0000000010; done = 1'b1; cnt = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); cnt += int'(sel_valid); end
    enq = '0; done = 1'b0;
    chk_rng("R8 grants with period 4", cnt, 9, 11);
    cbr_per = '0; do_reset();
    enq = 10'b0000000010; done = 1'b1; cnt = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); cnt += int'(sel_valid); end
    enq = '0; done = 1'b0;
    chk_rng("R8 grants ungated", cnt, 19, 21);

    // R9 overflow pulses
    cfg_clear(); set_q(1, 3'd1, 1'b0);
    cbr_per[TW*1 +: TW] = 8'd2; cbr_thr[TW*1 +: TW] = 8'd2;
    rst_n = 1'b0; enq = '0; repeat (2) @(negedge clk); rst_n = 1'b1;
    cnt = 0;
    for (int c = 0; c < 4; c++) begin @(negedge clk); cnt += int'(cbr_ovf[1]); end
    chk("R9 no early overflow", cnt, 0);
    cnt = 0;
    for (int c = 0; c < 16; c++) begin @(negedge clk); cnt += int'(cbr_ovf[1]); end
    chk_rng("R9 overflow seen", cnt, 1, 16);
    cbr_thr = '0; do_reset(); cnt = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); cnt += int'(cbr_ovf != '0); end
    chk("R9 zero threshold silent", cnt, 0);

    // R10 ready window
    cfg_clear(); set_q(4, 3'd1, 1'b0); rdy_time[TW*4 +: TW] = 8'd3; do_reset();
    pulse_enq(10'b0000010000);
    repeat (6) @(negedge clk);
    q_en[4] = 1'b1; repeat (2) @(negedge clk);
    chk("R10 closed window blocks", int'(sel_valid), 0);
    pulse_enq(10'b0000010000); @(negedge clk);
    chk("R10 reopened window grants", int'(sel_valid), 1);
    chk("R10 index", int'(sel_idx), 4);
    cfg_clear(); set_q(4, 3'd3, 1'b0); rdy_time[TW*4 +: TW] = 8'd3; do_reset();
    pulse_enq(10'b0000010000);
    repeat (6) @(negedge clk);
    q_en[4] = 1'b1; repeat (2) @(negedge clk);
    chk("R10 after-beacon type exempt", int'(sel_valid), 1);

    // R11 burst limit
    cfg_clear(); set_q(5, 3'd1, 1'b1); set_q(2, 3'd1, 1'b1);
    burst_time[TW*5 +: TW] = 8'd2; do_reset();
    enq = 10'b0000100100; done = 1'b1; k = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (sel_valid && k < 3) begin g[k] = int'(sel_idx); k++; end
    end
    enq = '0; done = 1'b0;
    chk("R11 grant 1", g[0], 5);
    chk("R11 grant 2", g[1], 5);
    chk("R11 grant 3 yields", g[2], 2);
    burst_time = '0; do_reset();
    enq = 10'b0000100100; done = 1'b1; k = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (sel_valid && k < 3) begin g[k] = int'(sel_idx); k++; end
    end
    enq = '0; done = 1'b0;
    chk("R11 unlimited keeps queue", g[2], 5);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule